// File: doc/BRIEF.md
# Indirect Waveform Coefficient Loader

This block takes a byte stream from a serial host port and loads a small coefficient store that defines custom transmit pulse shapes. Each byte arrives with a one-cycle valid strobe while a chip-select input is high. The first byte of a frame is a command byte. Its top bit is a write flag and its low seven bits are a register address. A write command aimed at the waveform register (address 0x13) opens a three-byte transaction. The next byte names a location in the store, and the byte after that is the coefficient to place there.

Any other command, including a read of 0x13, is handed on unchanged as an ordinary register access on a one-cycle request output. The store has 42 byte locations, 0x00 to 0x29. A pulse shaper reads them through a registered read port. A separate select output, taken from the RAM-pulse control bit, tells the shaper to use the stored shapes in place of the built-in ones.

The decoder has three states. `ST_CMD` waits for a command byte. `ST_LOC` waits for the location byte. `ST_COEF` waits for the coefficient byte. The transitions are:
- **open**: `ST_CMD` to `ST_LOC`, on a write command to 0x13.
- **pick**: `ST_LOC` to `ST_COEF`, on any byte.
- **commit**: `ST_COEF` to `ST_CMD`, on any byte.
- **abort**: any state to `ST_CMD`, when chip select drops.

Top module: `wfram_loader`

## Requirements
- R1: After reset every store location reads 0x00, `shape_sel` is 0, `req_valid` is 0, and the decoder is in `ST_CMD`.
- R2: Bit 7 of a command byte is the write flag (1 = write) and bits 6:0 are the register address. A command with the flag set and address 0x13 opens a transaction and produces no register request.
- R3: In an open transaction, the second accepted byte is the location and the third is the coefficient. The coefficient is stored at that location on the edge that accepts it. Setting `rd_addr` to the location returns the coefficient on `rd_data` after the next clock edge.
- R4: A location byte above 0x29 lets the transaction finish without changing any store contents. The byte after it is decoded as a command.
- R5: Chip select low for a cycle aborts an open transaction without a write. The next accepted byte is decoded as a command.
- R6: A command byte that does not open a transaction (another address, or the flag clear) raises `req_valid` for exactly one cycle after the accepting edge. `req_write` then equals bit 7 and `req_addr` equals bits 6:0.
- R7: A byte with `byte_valid` low is ignored and does not advance the decoder.
- R8: `shape_sel` equals the value `ram_pulse_en` had one clock edge earlier.
- R9: A read at an `rd_addr` above 0x29 returns 0x00.
- R10: Bytes presented while chip select is low are ignored.
- R11: A later write to the same location replaces the earlier coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, high while a frame is active |
| byte_valid | input | 1 | Strobe qualifying `byte_data` |
| byte_data | input | 8 | Incoming command, location or coefficient byte |
| ram_pulse_en | input | 1 | RAM-pulse control bit from the control register |
| rd_addr | input | 6 | Shaper read location |
| rd_data | output | 8 | Coefficient at `rd_addr`, one cycle later |
| shape_sel | output | 1 | 1 selects RAM-defined pulse shapes |
| req_valid | output | 1 | Pass-through register request strobe |
| req_write | output | 1 | Write flag of the passed request |
| req_addr | output | 7 | Register address of the passed request |

## Verification
The loader is tried with these input patterns:
- **Back-to-back transactions at both end locations (0x00 and 0x29).** These separate correct indexing from off-by-one decode.
- **An out-of-range location, 0x2A.** This shows the boundary compare is strict and that the decoder returns to command decoding.
- **Transactions broken by valid gaps carrying garbage data, and frames cut by chip-select drops.** These separate true byte counting from edge counting, and an aborted transaction from a completed one.
- **Pass-through commands, including a read of 0x13 and a write to a neighbouring register.** A scoreboard matches each expected request against the request port, so a command wrongly swallowed, or wrongly passed on, shows up as a mismatch.

// File: rtl/wfl_pkg.sv
package wfl_pkg;
    localparam int DW        = 8;
    localparam int RA_W      = 7;
    localparam int DEPTH     = 42;
    localparam int AW        = $clog2(DEPTH);
    localparam logic [RA_W-1:0] WAVE_REG = 7'h13;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_LOC  = 2'd1,
        ST_COEF = 2'd2
    } dec_state_t;
endpackage

// File: rtl/wfl_cmd_fsm.sv
module wfl_cmd_fsm
    import wfl_pkg::*;
#(
    parameter int P_DEPTH = DEPTH,
    parameter int P_AW    = AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             byte_valid,
    input  logic [DW-1:0]    byte_data,
    output dec_state_t       state_o,
    output logic             ram_we,
    output logic [P_AW-1:0]  ram_waddr,
    output logic [DW-1:0]    ram_wdata,
    output logic             req_valid,
    output logic             req_write,
    output logic [RA_W-1:0]  req_addr
);
    localparam logic [DW-1:0] LOC_LAST = DW'(P_DEPTH - 1);

    dec_state_t      state_q, state_d;
    logic [DW-1:0]   loc_q;
    logic            take;
    logic            cmd_opens;

    assign take      = cs && byte_valid;
    assign cmd_opens = byte_data[DW-1] && (byte_data[RA_W-1:0] == WAVE_REG);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs) begin
            state_d = ST_CMD;
        end else if (byte_valid) begin
            unique case (state_q)
                ST_CMD:  state_d = cmd_opens ? ST_LOC : ST_CMD;
                ST_LOC:  state_d = ST_COEF;
                ST_COEF: state_d = ST_CMD;
                default: state_d = ST_CMD;
            endcase
        end
    end

    // state register and held location
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            loc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take && state_q == ST_LOC) begin
                loc_q <= byte_data;
            end
        end
    end

    // outputs
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = loc_q[P_AW-1:0];
        ram_wdata = byte_data;
        unique case (state_q)
            ST_COEF: ram_we = take && (loc_q <= LOC_LAST);
            default: ram_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_write <= 1'b0;
            req_addr  <= '0;
        end else begin
            req_valid <= take && (state_q == ST_CMD) && !cmd_opens;
            if (take && state_q == ST_CMD) begin
                req_write <= byte_data[DW-1];
                req_addr  <= byte_data[RA_W-1:0];
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/wfl_coef_ram.sv
module wfl_coef_ram
    import wfl_pkg::*;
#(
    parameter int P_DEPTH = DEPTH,
    parameter int P_AW    = AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [P_AW-1:0]  waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [P_AW-1:0]  raddr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0]      mem [P_DEPTH];
    logic [P_DEPTH-1:0] hit;
    logic [DW-1:0]      rd_next;

    for (genvar g = 0; g < P_DEPTH; g++) begin : g_dec
        assign hit[g] = we && (waddr == P_AW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < P_DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < P_DEPTH; i++) begin
                if (hit[i]) mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < P_DEPTH; i++) begin
            if (raddr == P_AW'(i)) rd_next = mem[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end
endmodule

// File: rtl/wfl_sel_reg.sv
module wfl_sel_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic sel_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_out <= 1'b0;
        else        sel_out <= en_in;
    end
endmodule

// File: rtl/wfram_loader.sv
module wfram_loader
    import wfl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    input  logic            ram_pulse_en,
    input  logic [5:0]      rd_addr,
    output logic [7:0]      rd_data,
    output logic            shape_sel,
    output logic            req_valid,
    output logic            req_write,
    output logic [6:0]      req_addr
);
    dec_state_t           fsm_state;
    logic                 ram_we;
    logic [AW-1:0]        ram_waddr;
    logic [DW-1:0]        ram_wdata;

    wfl_cmd_fsm #(.P_DEPTH(DEPTH), .P_AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .state_o    (fsm_state),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr)
    );

    wfl_coef_ram #(.P_DEPTH(DEPTH), .P_AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    wfl_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_in   (ram_pulse_en),
        .sel_out (shape_sel)
    );
endmodule

// File: rtl/wfl_checker.sv
module wfl_checker
    import wfl_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cs,
    input logic            byte_valid,
    input logic [7:0]      byte_data,
    input logic            ram_pulse_en,
    input logic            shape_sel,
    input logic            req_valid,
    input logic            req_write,
    input logic [6:0]      req_addr,
    input dec_state_t      fsm_state,
    input logic            ram_we,
    input logic [AW-1:0]   ram_waddr
);
    // R4: the store is never written beyond its last location
    assert_write_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_waddr < AW'(DEPTH)));

    // R5: a dropped chip select returns the decoder to command wait
    assert_abort_on_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (fsm_state == ST_CMD));

    // R6: a request only follows a byte accepted in command wait
    assert_req_from_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(cs && byte_valid && fsm_state == ST_CMD));

    // R2: an opening command never leaks out as a request
    assert_open_not_passed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !(req_write && req_addr == WAVE_REG));

    // R7: without a valid byte the decoder holds its state
    assert_hold_without_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !byte_valid) |=> $stable(fsm_state));

    // R8: select follows the control bit after one edge
    assert_sel_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (shape_sel == $past(ram_pulse_en)));

    // R10: bytes with chip select low produce no write
    assert_no_write_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !ram_we);

    logic unused_ok;
    assign unused_ok = ^byte_data;
endmodule

bind wfram_loader wfl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs           (cs),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .ram_pulse_en (ram_pulse_en),
    .shape_sel    (shape_sel),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .fsm_state    (fsm_state),
    .ram_we       (ram_we),
    .ram_waddr    (ram_waddr)
);

// File: tb/tb_wfram_loader.sv
`timescale 1ns/1ps
module tb_wfram_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       ram_pulse_en = 1'b0;
    logic [5:0] rd_addr = 6'd0;
    logic [7:0] rd_data;
    logic       shape_sel;
    logic       req_valid;
    logic       req_write;
    logic [6:0] req_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    wfram_loader dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .byte_valid(byte_valid),
        .byte_data(byte_data), .ram_pulse_en(ram_pulse_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .shape_sel(shape_sel), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected requests as the design issues them (R6)
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected request", {req_write, req_addr}, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check({req_write, req_addr} == e, "R6 request", {req_write, req_addr}, e);
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = 8'h93;
    endtask

    task automatic send_cmd_pass(input logic [7:0] b);
        exp_q.push_back(b);
        send(b);
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        check(rd_data == e, req, rd_data, e);
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 0, 1);
        done = 1'b1;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(shape_sel == 1'b0, "R1 shape_sel", shape_sel, 0);
        check(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
        rst_n = 1'b1;
        rd_check(6'h00, 8'h00, "R1 loc 0x00");
        rd_check(6'h29, 8'h00, "R1 loc 0x29");
        cs = 1'b1;

        // R2 R3 lowest and highest location
        send(8'h93); send(8'h00); send(8'hA5);
        send(8'h93); send(8'h29); send(8'h3C);
        rd_check(6'h00, 8'hA5, "R3 loc 0x00");
        rd_check(6'h29, 8'h3C, "R3 loc 0x29");

        // R4 location out of range, then next byte is a command
        send(8'h93); send(8'h2A); send(8'hFF);
        rd_check(6'h29, 8'h3C, "R4 loc 0x29 untouched");
        send_cmd_pass(8'h05);
        rd_check(6'h00, 8'hA5, "R4 loc 0x00 untouched");

        // R9 read beyond the last location
        rd_check(6'h2A, 8'h00, "R9 read 0x2A");
        rd_check(6'h3F, 8'h00, "R9 read 0x3F");

        // R5 abort mid-transaction
        send(8'h93); send(8'h10);
        @(negedge clk); cs = 1'b0;
        @(negedge clk); cs = 1'b1;
        send_cmd_pass(8'h77);
        rd_check(6'h10, 8'h00, "R5 loc 0x10 not written");

        // R7 valid gaps with garbage data on the bus
        send(8'h93); repeat (3) @(negedge clk);
        send(8'h07); repeat (2) @(negedge clk);
        send(8'h5A);
        rd_check(6'h07, 8'h5A, "R7 loc 0x07 after gaps");

        // R10 bytes while deselected are ignored
        @(negedge clk); cs = 1'b0;
        send(8'h93); send(8'h08); send(8'h11);
        @(negedge clk); cs = 1'b1;
        send_cmd_pass(8'h10);
        rd_check(6'h08, 8'h00, "R10 loc 0x08 not written");

        // R6 pass-through: write to 0x11, read of 0x13 does not open
        send_cmd_pass(8'h91);
        send_cmd_pass(8'h13);
        send_cmd_pass(8'h85);
        rd_check(6'h05, 8'h00, "R6 loc 0x05 not written");

        // R11 overwrite
        send(8'h93); send(8'h07); send(8'hC3);
        rd_check(6'h07, 8'hC3, "R11 loc 0x07 overwritten");

        // R8 select follows control bit
        @(negedge clk); ram_pulse_en = 1'b1;
        @(negedge clk);
        check(shape_sel == 1'b1, "R8 select high", shape_sel, 1);
        ram_pulse_en = 1'b0;
        @(negedge clk);
        check(shape_sel == 1'b0, "R8 select low", shape_sel, 0);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6 missing request", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule